// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block decides, every cycle, whether the front end of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) may advance. It also decides which pipeline registers must be emptied. The pipeline is assumed to have forwarding paths. The controller looks at several inputs:

- the source operands of the instruction in decode;
- the destination and control flags of the instructions in execute, memory and writeback;
- the redirect indication from the branch unit in execute.

From these it drives the write enables for the PC and the decode registers, and synchronous clear requests for the decode, execute and memory input registers.

Three situations need action:

- **Load followed by its consumer.** A load in execute followed by an instruction in decode that reads the loaded register costs exactly one bubble. The load data only appears in the memory stage, too late to forward into execute.
- **Taken branch or jump.** A taken branch or jump resolved in execute discards the two younger instructions and lets the PC take the target.
- **Environment call.** An environment call in execute is held in place until no older register-writing instruction remains in memory or writeback. This ensures its register reads see committed values.

Every output is a combinational function of the stage contents, except for one flop that keeps all clears asserted during reset and for the first cycle after it.

Top module: `hazard_flush_ctrl`

## Requirements
- R1: With a load in execute that writes a nonzero register equal to a decode operand that is marked as read, the outputs are: PC write enable 0, decode write enable 0, execute-register clear 1 (bubble), decode clear 0, execute write enable 1, memory-register clear 0.
- R2: An operand whose use flag is 0 never causes a load-use stall, even when its index matches the load destination.
- R3: A destination of register 0 causes neither a load-use stall nor an environment-call wait.
- R4: A non-load instruction in execute never causes a stall, whatever its destination; forwarding serves it.
- R5: A taken redirect in execute gives: PC write enable 1, decode clear 1, execute-register clear 1, memory-register clear 0.
- R6: A taken redirect wins over a load-use stall or an environment-call wait arriving in the same cycle.
- R7: An environment call in execute, while the memory or writeback stage holds a valid write to a nonzero register, gives: PC, decode and execute write enables all 0, memory-register clear 1, decode and execute clears 0.
- R8: An environment call with no pending older register write proceeds: all write enables 1, all clears 0.
- R9: While reset is asserted, and in the first cycle after its release, the three clears are 1 and the three write enables are 0.
- R10: With no hazard, all three write enables are 1 and all three clears are 0. The PC and decode write enables are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ex_redirect | input | 1 | Branch or jump in execute is taken |
| ex_is_ecall | input | 1 | Instruction in execute is an environment call |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_rd | input | 5 | Destination register in execute |
| id_rs1 | input | 5 | First source register in decode |
| id_rs2 | input | 5 | Second source register in decode |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| mem_wr_en | input | 1 | Instruction in memory writes a register |
| mem_rd | input | 5 | Destination register in memory |
| wb_wr_en | input | 1 | Instruction in writeback writes a register |
| wb_rd | input | 5 | Destination register in writeback |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Decode register write enable |
| idex_we | output | 1 | Execute register write enable |
| ifid_clr | output | 1 | Clear decode register on next edge |
| idex_clr | output | 1 | Clear execute register on next edge |
| exmem_clr | output | 1 | Clear memory register on next edge |

## Verification
The hardest situations to reach are the collisions: a redirect in the same cycle as a load-use match or as an environment call with a pending writer, and a matching index whose use flag is clear or whose destination is register 0. In a real pipeline these need carefully arranged instruction streams. Because the bench drives every stage field directly, each collision is one row of its vector table. The one-cycle window after reset release is caught by releasing reset on a falling edge and sampling before the next rising edge.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [2:0] {
    CAUSE_INIT  = 3'd0,
    CAUSE_FLUSH = 3'd1,
    CAUSE_ECALL = 3'd2,
    CAUSE_LDUSE = 3'd3,
    CAUSE_NONE  = 3'd4
  } cause_e;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic idex_we;
    logic ifid_clr;
    logic idex_clr;
    logic exmem_clr;
  } ctl_t;

endpackage

// File: rtl/hzc_loaduse.sv
module hzc_loaduse #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                     ex_is_load,
  input  logic                     ex_wr_en,
  input  logic [AW-1:0]            ex_rd,
  input  logic [NSRC-1:0][AW-1:0]  src_idx,
  input  logic [NSRC-1:0]          src_used,
  output logic                     hit
);

  logic [NSRC-1:0] match;
  logic            dest_live;

  assign dest_live = ex_is_load && ex_wr_en && (ex_rd != '0);

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    assign match[gi] = src_used[gi] && (src_idx[gi] == ex_rd);
  end

  assign hit = dest_live && (|match);

endmodule

// File: rtl/hzc_ecall_wait.sv
module hzc_ecall_wait #(
  parameter int AW   = 5,
  parameter int NOLD = 2
) (
  input  logic                     ex_is_ecall,
  input  logic [NOLD-1:0]          old_wr,
  input  logic [NOLD-1:0][AW-1:0]  old_rd,
  output logic                     wait_req
);

  logic [NOLD-1:0] pending;

  for (genvar gi = 0; gi < NOLD; gi++) begin : g_old
    assign pending[gi] = old_wr[gi] && (old_rd[gi] != '0);
  end

  assign wait_req = ex_is_ecall && (|pending);

endmodule

// File: rtl/hzc_arbiter.sv
module hzc_arbiter
  import hzc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  redirect,
  input  logic  ecall_wait,
  input  logic  lduse,
  output ctl_t  ctl
);

  logic   init_q;
  logic   init_d;
  logic   init_en;
  cause_e cause;

  // next-state: the init flag drops after the first edge following reset
  always_comb begin
    init_en = init_q;
    init_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
    end else if (init_en) begin
      init_q <= init_d;
    end
  end

  // fixed priority: init > flush > ecall wait > load-use
  always_comb begin
    if (init_q)          cause = CAUSE_INIT;
    else if (redirect)   cause = CAUSE_FLUSH;
    else if (ecall_wait) cause = CAUSE_ECALL;
    else if (lduse)      cause = CAUSE_LDUSE;
    else                 cause = CAUSE_NONE;
  end

  always_comb begin
    ctl = '{pc_we: 1'b1, ifid_we: 1'b1, idex_we: 1'b1,
            ifid_clr: 1'b0, idex_clr: 1'b0, exmem_clr: 1'b0};
    unique case (cause)
      CAUSE_INIT: begin
        ctl.pc_we     = 1'b0;
        ctl.ifid_we   = 1'b0;
        ctl.idex_we   = 1'b0;
        ctl.ifid_clr  = 1'b1;
        ctl.idex_clr  = 1'b1;
        ctl.exmem_clr = 1'b1;
      end
      CAUSE_FLUSH: begin
        ctl.ifid_clr = 1'b1;
        ctl.idex_clr = 1'b1;
      end
      CAUSE_ECALL: begin
        ctl.pc_we     = 1'b0;
        ctl.ifid_we   = 1'b0;
        ctl.idex_we   = 1'b0;
        ctl.exmem_clr = 1'b1;
      end
      CAUSE_LDUSE: begin
        ctl.pc_we    = 1'b0;
        ctl.ifid_we  = 1'b0;
        ctl.idex_clr = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hazard_flush_ctrl.sv
module hazard_flush_ctrl
  import hzc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_redirect,
  input  logic          ex_is_ecall,
  input  logic          ex_is_load,
  input  logic          ex_wr_en,
  input  logic [AW-1:0] ex_rd,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_wr_en,
  input  logic [AW-1:0] wb_rd,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_we,
  output logic          ifid_clr,
  output logic          idex_clr,
  output logic          exmem_clr
);

  localparam int NSRC = 2;
  localparam int NOLD = 2;

  logic [NSRC-1:0][AW-1:0] src_idx;
  logic [NSRC-1:0]         src_used;
  logic [NOLD-1:0][AW-1:0] old_rd;
  logic [NOLD-1:0]         old_wr;
  logic                    lduse_hit;
  logic                    ecall_hold;
  ctl_t                    ctl;

  assign src_idx  = {id_rs2, id_rs1};
  assign src_used = {id_use_rs2, id_use_rs1};
  assign old_rd   = {wb_rd, mem_rd};
  assign old_wr   = {wb_wr_en, mem_wr_en};

  hzc_loaduse #(.AW(AW), .NSRC(NSRC)) u_lduse (
    .ex_is_load (ex_is_load),
    .ex_wr_en   (ex_wr_en),
    .ex_rd      (ex_rd),
    .src_idx    (src_idx),
    .src_used   (src_used),
    .hit        (lduse_hit)
  );

  hzc_ecall_wait #(.AW(AW), .NOLD(NOLD)) u_ecall (
    .ex_is_ecall (ex_is_ecall),
    .old_wr      (old_wr),
    .old_rd      (old_rd),
    .wait_req    (ecall_hold)
  );

  hzc_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .redirect   (ex_redirect),
    .ecall_wait (ecall_hold),
    .lduse      (lduse_hit),
    .ctl        (ctl)
  );

  assign pc_we     = ctl.pc_we;
  assign ifid_we   = ctl.ifid_we;
  assign idex_we   = ctl.idex_we;
  assign ifid_clr  = ctl.ifid_clr;
  assign idex_clr  = ctl.idex_clr;
  assign exmem_clr = ctl.exmem_clr;

endmodule

// File: rtl/hazard_flush_ctrl_chk.sv
module hazard_flush_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ex_redirect,
  input logic          ex_is_ecall,
  input logic          ex_is_load,
  input logic          ex_wr_en,
  input logic [AW-1:0] ex_rd,
  input logic [AW-1:0] id_rs1,
  input logic          id_use_rs1,
  input logic          id_use_rs2,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_rd,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_we,
  input logic          ifid_clr,
  input logic          idex_clr,
  input logic          exmem_clr
);

  logic warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  a_r1_load_use_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !ex_redirect && !ex_is_ecall && ex_is_load && ex_wr_en &&
     ex_rd != '0 && id_use_rs1 && id_rs1 == ex_rd)
    |-> (!pc_we && !ifid_we && idex_clr && !ifid_clr));

  a_r2_unused_operands: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !ex_redirect && !ex_is_ecall && !id_use_rs1 && !id_use_rs2)
    |-> (pc_we && !idex_clr));

  a_r3_x0_dest_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !ex_redirect && !ex_is_ecall && ex_rd == '0) |-> pc_we);

  a_r4_alu_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !ex_redirect && !ex_is_ecall && !ex_is_load) |-> (pc_we && ifid_we));

  a_r5_redirect_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ex_redirect) |-> (pc_we && ifid_clr && idex_clr && !exmem_clr));

  a_r7_ecall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !ex_redirect && ex_is_ecall && mem_wr_en && mem_rd != '0)
    |-> (!pc_we && !idex_we && exmem_clr && !idex_clr));

  a_r9_init_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !warm |-> (ifid_clr && idex_clr && exmem_clr && !pc_we));

  a_r10_we_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we == ifid_we);

endmodule

bind hazard_flush_ctrl hazard_flush_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ex_redirect(ex_redirect),
  .ex_is_ecall(ex_is_ecall),
  .ex_is_load (ex_is_load),
  .ex_wr_en   (ex_wr_en),
  .ex_rd      (ex_rd),
  .id_rs1     (id_rs1),
  .id_use_rs1 (id_use_rs1),
  .id_use_rs2 (id_use_rs2),
  .mem_wr_en  (mem_wr_en),
  .mem_rd     (mem_rd),
  .pc_we      (pc_we),
  .ifid_we    (ifid_we),
  .idex_we    (idex_we),
  .ifid_clr   (ifid_clr),
  .idex_clr   (idex_clr),
  .exmem_clr  (exmem_clr)
);

// File: tb/tb_hazard_flush_ctrl.sv
module tb_hazard_flush_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  // output code order: {pc_we, ifid_we, idex_we, ifid_clr, idex_clr, exmem_clr}
  localparam logic [5:0] O_IDLE  = 6'b111000;
  localparam logic [5:0] O_LDUSE = 6'b001010;
  localparam logic [5:0] O_FLUSH = 6'b111110;
  localparam logic [5:0] O_ECALL = 6'b000001;
  localparam logic [5:0] O_INIT  = 6'b000111;

  typedef struct packed {
    logic [3:0] req;
    logic       rdr, ecl, ld, exw;
    logic [4:0] exrd, rs1, rs2;
    logic       u1, u2, mw;
    logic [4:0] mrd;
    logic       ww;
    logic [4:0] wrd;
    logic [5:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd10, 1'b0,1'b0,1'b0,1'b0, 5'd0, 5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd0, 1'b0, 5'd0, O_IDLE},  // R10
    '{4'd1,  1'b0,1'b0,1'b1,1'b1, 5'd5, 5'd5, 5'd2, 1'b1,1'b0,1'b0, 5'd0, 1'b0, 5'd0, O_LDUSE}, // R1 rs1
    '{4'd1,  1'b0,1'b0,1'b1,1'b1, 5'd7, 5'd3, 5'd7, 1'b1,1'b1,1'b0, 5'd0, 1'b0, 5'd0, O_LDUSE}, // R1 rs2
    '{4'd2,  1'b0,1'b0,1'b1,1'b1, 5'd5, 5'd5, 5'd2, 1'b0,1'b0,1'b0, 5'd0, 1'b0, 5'd0, O_IDLE},  // R2
    '{4'd2,  1'b0,1'b0,1'b1,1'b1, 5'd7, 5'd3, 5'd7, 1'b1,1'b0,1'b0, 5'd0, 1'b0, 5'd0, O_IDLE},  // R2
    '{4'd3,  1'b0,1'b0,1'b1,1'b1, 5'd0, 5'd0, 5'd0, 1'b1,1'b1,1'b0, 5'd0, 1'b0, 5'd0, O_IDLE},  // R3 load
    '{4'd4,  1'b0,1'b0,1'b0,1'b1, 5'd5, 5'd5, 5'd5, 1'b1,1'b1,1'b0, 5'd0, 1'b0, 5'd0, O_IDLE},  // R4
    '{4'd5,  1'b1,1'b0,1'b0,1'b0, 5'd0, 5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd0, 1'b0, 5'd0, O_FLUSH}, // R5
    '{4'd6,  1'b1,1'b0,1'b1,1'b1, 5'd9, 5'd9, 5'd2, 1'b1,1'b0,1'b0, 5'd0, 1'b0, 5'd0, O_FLUSH}, // R6 vs load-use
    '{4'd7,  1'b0,1'b1,1'b0,1'b0, 5'd0, 5'd10,5'd17,1'b1,1'b1,1'b1, 5'd3, 1'b0, 5'd0, O_ECALL}, // R7 mem
    '{4'd7,  1'b0,1'b1,1'b0,1'b0, 5'd0, 5'd10,5'd17,1'b1,1'b1,1'b0, 5'd0, 1'b1, 5'd9, O_ECALL}, // R7 wb
    '{4'd8,  1'b0,1'b1,1'b0,1'b0, 5'd0, 5'd10,5'd17,1'b1,1'b1,1'b0, 5'd0, 1'b0, 5'd0, O_IDLE},  // R8
    '{4'd3,  1'b0,1'b1,1'b0,1'b0, 5'd0, 5'd10,5'd17,1'b1,1'b1,1'b1, 5'd0, 1'b1, 5'd0, O_IDLE},  // R3 ecall
    '{4'd8,  1'b0,1'b1,1'b0,1'b0, 5'd0, 5'd10,5'd17,1'b1,1'b1,1'b0, 5'd4, 1'b0, 5'd6, O_IDLE},  // R8 no wr_en
    '{4'd6,  1'b1,1'b1,1'b0,1'b0, 5'd0, 5'd10,5'd17,1'b1,1'b1,1'b1, 5'd3, 1'b1, 5'd9, O_FLUSH}  // R6 vs ecall
  };

  logic       clk;
  logic       rst_n;
  logic       ex_redirect, ex_is_ecall, ex_is_load, ex_wr_en;
  logic [4:0] ex_rd, id_rs1, id_rs2, mem_rd, wb_rd;
  logic       id_use_rs1, id_use_rs2, mem_wr_en, wb_wr_en;
  logic       pc_we, ifid_we, idex_we, ifid_clr, idex_clr, exmem_clr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  hazard_flush_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .ex_redirect(ex_redirect), .ex_is_ecall(ex_is_ecall),
    .ex_is_load(ex_is_load), .ex_wr_en(ex_wr_en), .ex_rd(ex_rd),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .mem_wr_en(mem_wr_en), .mem_rd(mem_rd),
    .wb_wr_en(wb_wr_en), .wb_rd(wb_rd),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_we(idex_we),
    .ifid_clr(ifid_clr), .idex_clr(idex_clr), .exmem_clr(exmem_clr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] got();
    return {pc_we, ifid_we, idex_we, ifid_clr, idex_clr, exmem_clr};
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    total++;
    if (got() !== exp) begin
      bad++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, got(), exp);
    end
  endtask

  task automatic apply(input vec_t v);
    ex_redirect = v.rdr; ex_is_ecall = v.ecl; ex_is_load = v.ld;
    ex_wr_en = v.exw; ex_rd = v.exrd; id_rs1 = v.rs1; id_rs2 = v.rs2;
    id_use_rs1 = v.u1; id_use_rs2 = v.u2; mem_wr_en = v.mw; mem_rd = v.mrd;
    wb_wr_en = v.ww; wb_rd = v.wrd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    apply(VEC[0]);
    // R9: during reset with a flush-worthy input, init still dominates
    #(CLK_PERIOD*2 + 1);
    ex_redirect = 1'b1;
    #1 check("R9 in reset", O_INIT);
    ex_redirect = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R9 first cycle after release", O_INIT);
    @(posedge clk);
    @(negedge clk);
    #1 check("R10 idle after init", O_IDLE);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #1 check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
    end

    // R1: load-use stall persists while stage contents are held
    @(negedge clk);
    apply(VEC[1]);
    @(negedge clk);
    #1 check("R1 held stall second cycle", O_LDUSE);
    // R4: after the bubble the load moves on; consumer sees a non-load in EX
    @(negedge clk);
    ex_is_load = 1'b0;
    #1 check("R4 after bubble", O_IDLE);
    // R7 then R8: ecall released once writers drain
    @(negedge clk);
    apply(VEC[9]);
    #1 check("R7 wait with mem writer", O_ECALL);
    @(negedge clk);
    mem_wr_en = 1'b0; wb_wr_en = 1'b1; wb_rd = 5'd3;
    #1 check("R7 wait with wb writer", O_ECALL);
    @(negedge clk);
    wb_wr_en = 1'b0;
    #1 check("R8 release after drain", O_IDLE);

    // R9: reset reasserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R9 reasserted reset", O_INIT);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1 check("R10 idle after second reset", O_IDLE);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule